// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a bank of one-bit ownership tokens that two independent ports, left and right, share. Software on each side uses the tokens to agree on who may touch a region of shared memory. To claim a token, a port writes a zero to it. The port then reads the token back: a zero means the port holds it, and a one means it does not.

Each port has its own token select, its own memory select, a write strobe, a token address and a one-bit data line. The input and output directions of the data line are kept as separate signals. When both ports ask for the same free token on the same clock edge, a fixed priority decides: the left port wins and the right port's request is queued. A request for a token that the other port already holds is also queued, so the token passes straight to the waiting port when the holder gives it up. The holder gives a token up by writing a one to it.

Top module: `dpsem_unit`

## Requirements
- R1: After the synchronous active-high reset, every token is free, and both `l_rdat` and `r_rdat` read 1.
- R2: A port accesses a token only on a rising edge where its token select is 0 and its memory select is 1. On any other edge the port changes no token state and its read output holds its value.
- R3: A valid write with data 0 to a free token gives that token to the writing port on the same edge.
- R4: A valid read (`*_we_n` = 1) loads the port's read output on that edge. The value is 0 if the port held the addressed token just before the edge, and 1 otherwise. The other port therefore reads 1 while the token is held.
- R5: If both ports write 0 to the same free token on the same edge, the left port gets it and the right port does not. The right port's request stays queued.
- R6: A valid write with data 1 from the holding port releases the token. The token becomes free if the other port has no queued request.
- R7: A write with data 1 from a port that does not hold the token leaves token ownership unchanged.
- R8: A write with data 0 to a token held by the other port queues the request. When the holder releases the token, ownership passes to the queued port on that same edge.
- R9: The 3-bit address selects one of eight tokens, and each token's ownership is independent of the others.
- R10: The read output changes only on a valid read edge. It stays stable across idle edges and across write edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_tok_sel_n | input | 1 | Left token select, active low |
| l_mem_sel_n | input | 1 | Left memory select, active low. Must be 1 for a token access |
| l_we_n | input | 1 | Left write strobe, active low. 1 means read |
| l_addr | input | 3 | Left token address |
| l_wdat | input | 1 | Left write data: 0 to request, 1 to release |
| l_rdat | output | 1 | Left registered read data: 0 if owned |
| r_tok_sel_n | input | 1 | Right token select, active low |
| r_mem_sel_n | input | 1 | Right memory select, active low. Must be 1 for a token access |
| r_we_n | input | 1 | Right write strobe, active low. 1 means read |
| r_addr | input | 3 | Right token address |
| r_wdat | input | 1 | Right write data: 0 to request, 1 to release |
| r_rdat | output | 1 | Right registered read data: 0 if owned |

## Verification
The bench goes after several corner cases:

- Same-edge contention for one free token. A design that granted both ports, or neither, would show two zeros or two ones when both ports read the token back.
- A release written by the non-holder. A design that let it free the token would let the other port claim a held token.
- A queued request followed by the holder's release. A design that dropped the queue would leave the token free instead of owned by the waiting port.
- Writes with the memory select low. A design that ignored the select qualifiers would grant tokens on accesses meant for the memory.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

endpackage

// File: rtl/dpsem_port_dec.sv
module dpsem_port_dec #(
  parameter int NUM_TOK = 8,
  localparam int AW = $clog2(NUM_TOK)
) (
  input  logic               tok_sel_n,
  input  logic               mem_sel_n,
  input  logic               we_n,
  input  logic [AW-1:0]      addr,
  input  logic               wdat,
  output logic [NUM_TOK-1:0] req_vec,
  output logic [NUM_TOK-1:0] rel_vec,
  output logic               rd_stb
);

  logic acc;

  assign acc    = !tok_sel_n && mem_sel_n;
  assign rd_stb = acc && we_n;

  for (genvar t = 0; t < NUM_TOK; t++) begin : g_dec
    logic hit;
    assign hit        = acc && !we_n && (addr == AW'(t));
    assign req_vec[t] = hit && !wdat;
    assign rel_vec[t] = hit && wdat;
  end

endmodule

// File: rtl/dpsem_token.sv
module dpsem_token
  import dpsem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       l_req,
  input  logic       l_rel,
  input  logic       r_req,
  input  logic       r_rel,
  output logic [1:0] owner,
  output logic       l_pend,
  output logic       r_pend
);

  owner_e own_q, own_d;
  logic   lp_q, lp_d, rp_q, rp_d;

  always_comb begin
    // Queue requests from any port that does not already hold the token.
    lp_d  = (lp_q | l_req) & (own_q != OWN_LEFT);
    rp_d  = (rp_q | r_req) & (own_q != OWN_RIGHT);
    own_d = own_q;
    // Only the holder may release.
    if ((own_q == OWN_LEFT && l_rel) || (own_q == OWN_RIGHT && r_rel))
      own_d = OWN_NONE;
    // Grant a free token, left side first.
    if (own_d == OWN_NONE) begin
      if (lp_d) begin
        own_d = OWN_LEFT;
        lp_d  = 1'b0;
      end else if (rp_d) begin
        own_d = OWN_RIGHT;
        rp_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= OWN_NONE;
      lp_q  <= 1'b0;
      rp_q  <= 1'b0;
    end else begin
      own_q <= own_d;
      lp_q  <= lp_d;
      rp_q  <= rp_d;
    end
  end

  assign owner  = own_q;
  assign l_pend = lp_q;
  assign r_pend = rp_q;

endmodule

// File: rtl/dpsem_rdport.sv
module dpsem_rdport #(
  parameter int         NUM_TOK = 8,
  parameter logic [1:0] SIDE_ID = 2'd1,
  localparam int AW = $clog2(NUM_TOK)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_stb,
  input  logic [AW-1:0]        addr,
  input  logic [2*NUM_TOK-1:0] own_flat,
  output logic                 rdat
);

  logic [1:0] sel_own;

  assign sel_own = own_flat[{addr, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (rst)
      rdat <= 1'b1;
    else if (rd_stb)
      rdat <= (sel_own != SIDE_ID);
  end

endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit
  import dpsem_pkg::*;
#(
  parameter int NUM_TOK = 8,
  localparam int AW = $clog2(NUM_TOK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_tok_sel_n,
  input  logic          l_mem_sel_n,
  input  logic          l_we_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wdat,
  output logic          l_rdat,
  input  logic          r_tok_sel_n,
  input  logic          r_mem_sel_n,
  input  logic          r_we_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wdat,
  output logic          r_rdat
);

  logic [NUM_TOK-1:0]   l_req, l_rel, r_req, r_rel;
  logic                 l_rd, r_rd;
  logic [2*NUM_TOK-1:0] own_flat;
  logic [NUM_TOK-1:0]   l_pend_vec, r_pend_vec;

  dpsem_port_dec #(.NUM_TOK(NUM_TOK)) l_dec_i (
    .tok_sel_n(l_tok_sel_n), .mem_sel_n(l_mem_sel_n), .we_n(l_we_n),
    .addr(l_addr), .wdat(l_wdat),
    .req_vec(l_req), .rel_vec(l_rel), .rd_stb(l_rd)
  );

  dpsem_port_dec #(.NUM_TOK(NUM_TOK)) r_dec_i (
    .tok_sel_n(r_tok_sel_n), .mem_sel_n(r_mem_sel_n), .we_n(r_we_n),
    .addr(r_addr), .wdat(r_wdat),
    .req_vec(r_req), .rel_vec(r_rel), .rd_stb(r_rd)
  );

  for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
    dpsem_token tok_i (
      .clk(clk), .rst(rst),
      .l_req(l_req[t]), .l_rel(l_rel[t]),
      .r_req(r_req[t]), .r_rel(r_rel[t]),
      .owner(own_flat[2*t +: 2]),
      .l_pend(l_pend_vec[t]), .r_pend(r_pend_vec[t])
    );
  end

  dpsem_rdport #(.NUM_TOK(NUM_TOK), .SIDE_ID(OWN_LEFT)) l_rdp_i (
    .clk(clk), .rst(rst), .rd_stb(l_rd), .addr(l_addr),
    .own_flat(own_flat), .rdat(l_rdat)
  );

  dpsem_rdport #(.NUM_TOK(NUM_TOK), .SIDE_ID(OWN_RIGHT)) r_rdp_i (
    .clk(clk), .rst(rst), .rd_stb(r_rd), .addr(r_addr),
    .own_flat(own_flat), .rdat(r_rdat)
  );

endmodule

// File: rtl/dpsem_unit_chk.sv
module dpsem_unit_chk
  import dpsem_pkg::*;
#(
  parameter int NUM_TOK = 8,
  localparam int AW = $clog2(NUM_TOK)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 l_tok_sel_n,
  input logic                 l_mem_sel_n,
  input logic                 l_we_n,
  input logic [AW-1:0]        l_addr,
  input logic                 l_wdat,
  input logic                 l_rdat,
  input logic                 r_tok_sel_n,
  input logic                 r_mem_sel_n,
  input logic                 r_we_n,
  input logic [AW-1:0]        r_addr,
  input logic                 r_wdat,
  input logic                 r_rdat,
  input logic [2*NUM_TOK-1:0] own_flat,
  input logic [NUM_TOK-1:0]   r_pend_vec
);

  function automatic logic [1:0] own_of(input logic [2*NUM_TOK-1:0] v,
                                        input logic [AW-1:0] a);
    return v[{a, 1'b0} +: 2];
  endfunction

  logic lv, rv;
  assign lv = !l_tok_sel_n && l_mem_sel_n;
  assign rv = !r_tok_sel_n && r_mem_sel_n;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lv && !rv) |=> ($stable(own_flat) && $stable(l_rdat) && $stable(r_rdat)));

  // R3
  left_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && !l_we_n && !l_wdat && own_of(own_flat, l_addr) == OWN_NONE)
    |=> (own_of(own_flat, $past(l_addr)) == OWN_LEFT));

  // R4
  left_read_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && l_we_n)
    |=> (l_rdat == (own_of($past(own_flat), $past(l_addr)) != OWN_LEFT)));

  // R4
  right_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rv && r_we_n)
    |=> (r_rdat == (own_of($past(own_flat), $past(r_addr)) != OWN_RIGHT)));

  // R5
  tie_left_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && rv && !l_we_n && !r_we_n && !l_wdat && !r_wdat &&
     l_addr == r_addr && own_of(own_flat, l_addr) == OWN_NONE)
    |=> (own_of(own_flat, $past(l_addr)) == OWN_LEFT));

  // R7
  foreign_release_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && !l_we_n && l_wdat && own_of(own_flat, l_addr) == OWN_RIGHT && !rv)
    |=> $stable(own_flat));

  // R8
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && !l_we_n && l_wdat && own_of(own_flat, l_addr) == OWN_LEFT &&
     r_pend_vec[l_addr] && !rv)
    |=> (own_of(own_flat, $past(l_addr)) == OWN_RIGHT));

endmodule

bind dpsem_unit dpsem_unit_chk #(.NUM_TOK(NUM_TOK)) chk_i (
  .clk(clk), .rst(rst),
  .l_tok_sel_n(l_tok_sel_n), .l_mem_sel_n(l_mem_sel_n), .l_we_n(l_we_n),
  .l_addr(l_addr), .l_wdat(l_wdat), .l_rdat(l_rdat),
  .r_tok_sel_n(r_tok_sel_n), .r_mem_sel_n(r_mem_sel_n), .r_we_n(r_we_n),
  .r_addr(r_addr), .r_wdat(r_wdat), .r_rdat(r_rdat),
  .own_flat(own_flat), .r_pend_vec(r_pend_vec)
);

// File: tb/dpsem_unit_tb_top.sv
module dpsem_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       l_tok_sel_n = 1'b1, l_mem_sel_n = 1'b1, l_we_n = 1'b1, l_wdat = 1'b1;
  logic [2:0] l_addr = '0;
  logic       r_tok_sel_n = 1'b1, r_mem_sel_n = 1'b1, r_we_n = 1'b1, r_wdat = 1'b1;
  logic [2:0] r_addr = '0;
  logic       l_rdat, r_rdat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dpsem_unit #(.NUM_TOK(8)) dut_i (
    .clk(clk), .rst(rst),
    .l_tok_sel_n(l_tok_sel_n), .l_mem_sel_n(l_mem_sel_n), .l_we_n(l_we_n),
    .l_addr(l_addr), .l_wdat(l_wdat), .l_rdat(l_rdat),
    .r_tok_sel_n(r_tok_sel_n), .r_mem_sel_n(r_mem_sel_n), .r_we_n(r_we_n),
    .r_addr(r_addr), .r_wdat(r_wdat), .r_rdat(r_rdat)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One edge with both ports driven; returns at the next falling edge.
  // wr=1 means a write (we_n=0); on=1 means a valid token access.
  task automatic step(input bit lon, input bit lwr, input logic [2:0] la, input bit ld,
                      input bit ron, input bit rwr, input logic [2:0] ra, input bit rd);
    l_tok_sel_n = !lon; l_mem_sel_n = 1'b1; l_we_n = !lwr; l_addr = la; l_wdat = ld;
    r_tok_sel_n = !ron; r_mem_sel_n = 1'b1; r_we_n = !rwr; r_addr = ra; r_wdat = rd;
    @(negedge clk);
    l_tok_sel_n = 1'b1; l_we_n = 1'b1;
    r_tok_sel_n = 1'b1; r_we_n = 1'b1;
  endtask

  task automatic lw(input logic [2:0] a, input bit d); step(1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic rw(input logic [2:0] a, input bit d); step(0, 0, 0, 0, 1, 1, a, d); endtask
  task automatic lr(input logic [2:0] a); step(1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic rr(input logic [2:0] a); step(0, 0, 0, 0, 1, 0, a, 0); endtask

  task automatic t_reset();
    chk("R1 left out after reset", l_rdat, 1'b1);
    chk("R1 right out after reset", r_rdat, 1'b1);
    for (int a = 0; a < 8; a++) begin
      step(1, 0, 3'(a), 0, 1, 0, 3'(a), 0);
      chk("R1 left token free", l_rdat, 1'b1);
      chk("R1 right token free", r_rdat, 1'b1);
    end
  endtask

  task automatic t_claim();
    lw(3'd3, 1'b0);
    lr(3'd3);
    chk("R3 left owns token 3", l_rdat, 1'b0);
    rr(3'd3);
    chk("R4 right sees token 3 held", r_rdat, 1'b1);
    lr(3'd4);
    chk("R9 token 4 still free", l_rdat, 1'b1);
  endtask

  task automatic t_gate();
    // Request token 5 with memory select low: must be ignored.
    l_tok_sel_n = 1'b0; l_mem_sel_n = 1'b0; l_we_n = 1'b0; l_addr = 3'd5; l_wdat = 1'b0;
    @(negedge clk);
    l_tok_sel_n = 1'b1; l_mem_sel_n = 1'b1; l_we_n = 1'b1;
    lr(3'd5);
    chk("R2 gated request ignored", l_rdat, 1'b1);
    lr(3'd3);
    chk("R4 left reads 3 held", l_rdat, 1'b0);
    // Read attempt on token 5 with token select high: output must hold.
    l_tok_sel_n = 1'b1; l_we_n = 1'b1; l_addr = 3'd5;
    @(negedge clk);
    chk("R2 deselected read holds output", l_rdat, 1'b0);
    lw(3'd6, 1'b1);
    chk("R10 write edge holds output", l_rdat, 1'b0);
  endtask

  task automatic t_release();
    rw(3'd3, 1'b1);
    lr(3'd3);
    chk("R7 non-holder release ignored", l_rdat, 1'b0);
    lw(3'd3, 1'b1);
    step(1, 0, 3'd3, 0, 1, 0, 3'd3, 0);
    chk("R6 left released token 3", l_rdat, 1'b1);
    chk("R6 right sees token 3 free", r_rdat, 1'b1);
    rw(3'd3, 1'b0);
    rr(3'd3);
    chk("R6 right claims freed token", r_rdat, 1'b0);
  endtask

  task automatic t_pending();
    lw(3'd3, 1'b0);
    lr(3'd3);
    chk("R8 queued request not granted", l_rdat, 1'b1);
    rw(3'd3, 1'b1);
    step(1, 0, 3'd3, 0, 1, 0, 3'd3, 0);
    chk("R8 token passed to left", l_rdat, 1'b0);
    chk("R8 right no longer owns", r_rdat, 1'b1);
  endtask

  task automatic t_contend();
    step(1, 1, 3'd6, 0, 1, 1, 3'd6, 0);
    step(1, 0, 3'd6, 0, 1, 0, 3'd6, 0);
    chk("R5 left wins tie", l_rdat, 1'b0);
    chk("R5 right loses tie", r_rdat, 1'b1);
    lw(3'd6, 1'b1);
    rr(3'd6);
    chk("R5 queued loser gets token on release", r_rdat, 1'b0);
  endtask

  task automatic t_spread();
    // Tokens 3 and 6 are currently held by left and right; use the others.
    step(1, 1, 3'd0, 0, 1, 1, 3'd1, 0);
    step(1, 1, 3'd2, 0, 1, 1, 3'd7, 0);
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0);
    chk("R9 left owns 0", l_rdat, 1'b0);
    chk("R9 right not owner of 0", r_rdat, 1'b1);
    step(1, 0, 3'd7, 0, 1, 0, 3'd7, 0);
    chk("R9 left not owner of 7", l_rdat, 1'b1);
    chk("R9 right owns 7", r_rdat, 1'b0);
    step(1, 0, 3'd2, 0, 1, 0, 3'd1, 0);
    chk("R9 left owns 2", l_rdat, 1'b0);
    chk("R9 right owns 1", r_rdat, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_claim();
    t_gate();
    t_release();
    t_pending();
    t_contend();
    t_spread();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule